// File: doc/BRIEF.md
# Paged Write Buffer with Timed Commit

This block sits behind a two-wire bus slave and in front of a 128-byte storage array split into 32 pages of 4 bytes. The slave hands it a 7-bit word address, then any number of data bytes, then a stop. Bytes collect in a one-page staging buffer. The upper five address bits fix the page for the whole transfer. The lower two bits form a column pointer that advances after each byte and wraps inside the page, so a fifth byte lands on top of the first.

A stop that ends a transfer holding at least one byte starts a self-timed commit. The block then raises a busy flag for a fixed number of clock cycles. During that time it ignores every strobe and refuses reads, which lets the slave NACK address polls until the flag drops. When the cycle ends, only the columns that actually received a byte are written into the array. The other bytes of the page keep their old contents. The read port returns committed array contents one cycle after a request, and only while the block is idle.

Top module: `page_wr_engine`

## Requirements
- R1: After reset, busy_o and rd_ack_o are 0, rd_data_o is 0 and every array byte reads as 0.
- R2: An address load sets the page to addr_i[6:2] and the column to addr_i[1:0], discards any staged bytes, and opens a transfer.
- R3: Each data byte accepted in an open transfer is staged at the current column. The column then advances by one modulo 4 and the page does not change.
- R4: With more than four bytes in a transfer, column 3 is followed by column 0 of the same page, and a later byte replaces the earlier byte staged at that column.
- R5: A commit writes only the columns that received a byte during the transfer. Every other array byte keeps its value.
- R6: A stop that closes a transfer with at least one staged byte raises busy_o from the next cycle for exactly WR_CYCLES cycles. The array holds the new bytes from the cycle in which busy_o falls.
- R7: A stop that closes a transfer with no staged byte, or that arrives with no open transfer, leaves busy_o low. Data strobes with no open transfer are dropped.
- R8: While busy_o is high, address loads, data strobes, stops and read requests have no effect, and rd_ack_o stays 0. A stop closes the transfer, so data sent during busy is not staged.
- R9: When idle, a read request returns the committed byte at rd_addr_i on rd_data_o, with rd_ack_o high in the following cycle. rd_ack_o is 0 after any cycle without a served request.
- R10: When strobes coincide in an idle cycle, a stop takes priority over an address load, and an address load takes priority over a data strobe. The losing strobes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Load the word address and open a transfer |
| addr_i | input | 7 | Word address: page in [6:2], column in [1:0] |
| data_valid_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop condition seen on the bus |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 7 | Read address |
| rd_data_o | output | 8 | Read data, valid when rd_ack_o is high |
| rd_ack_o | output | 1 | Read request was served in the previous cycle |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
Several properties are checked on every cycle:
- the column wraps from 3 to 0;
- the page stays fixed while bytes arrive;
- a received byte sets its column's mask bit;
- a running write cycle holds busy until its counter runs out;
- reads are refused while busy;
- a commit never starts with an empty mask;
- the array changes only on a commit strobe.

Other behaviour can only be shown by the bench's sweep, which tries every page, every start column and transfer lengths from zero to six bytes against an arithmetic model of the array. This covers the exact busy length, the final contents of each page after wrap-around overwrites, the preservation of untouched bytes, the strobes dropped during busy, and the priority between coinciding strobes.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  localparam int unsigned ADDR_W_DEF = 7;
  localparam int unsigned COL_W_DEF  = 2;
  localparam int unsigned DATA_W_DEF = 8;

  typedef enum logic [0:0] {
    PH_OPEN   = 1'b0,
    PH_COMMIT = 1'b1
  } phase_e;
endpackage

// File: rtl/pwe_page_buf.sv
module pwe_page_buf #(
  parameter int unsigned ADDR_W = pwe_pkg::ADDR_W_DEF,
  parameter int unsigned COL_W  = pwe_pkg::COL_W_DEF,
  parameter int unsigned DATA_W = pwe_pkg::DATA_W_DEF,
  localparam int unsigned PAGE_W = ADDR_W - COL_W,
  localparam int unsigned NBYTES = 1 << COL_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          push_i,
  input  logic [DATA_W-1:0]             data_i,
  input  logic                          close_i,
  output logic [PAGE_W-1:0]             page_o,
  output logic [NBYTES-1:0][DATA_W-1:0] bytes_o,
  output logic [NBYTES-1:0]             mask_o,
  output logic                          open_o
);
  logic [COL_W-1:0]              col_q;
  logic [PAGE_W-1:0]             page_q;
  logic [NBYTES-1:0]             mask_q;
  logic [NBYTES-1:0][DATA_W-1:0] bytes_q;
  logic                          open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      page_q <= '0;
      mask_q <= '0;
      open_q <= 1'b0;
    end else if (close_i) begin
      open_q <= 1'b0;
    end else if (load_i) begin
      page_q <= addr_i[ADDR_W-1:COL_W];
      col_q  <= addr_i[COL_W-1:0];
      mask_q <= '0;
      open_q <= 1'b1;
    end else if (push_i) begin
      mask_q[col_q] <= 1'b1;
      col_q         <= col_q + 1'b1;
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        bytes_q[b] <= '0;
      else if (push_i && !load_i && !close_i && col_q == COL_W'(b))
        bytes_q[b] <= data_i;
    end
  end

  assign page_o  = page_q;
  assign bytes_o = bytes_q;
  assign mask_o  = mask_q;
  assign open_o  = open_q;

  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !load_i && !close_i |=> $stable(page_q)) else $error("page moved"); // R3
  AST_COL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !load_i && !close_i && col_q == '1 |=> col_q == '0) else $error("no wrap"); // R4
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !load_i && !close_i |=> mask_q[$past(col_q)]) else $error("mask"); // R5
endmodule

// File: rtl/pwe_wr_timer.sv
module pwe_wr_timer #(
  parameter int unsigned CYC = 1250000,
  localparam int unsigned CNT_W = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> busy_q) else $error("busy dropped early"); // R6
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> busy_q) else $error("no busy"); // R6
endmodule

// File: rtl/pwe_array.sv
module pwe_array #(
  parameter int unsigned ADDR_W = pwe_pkg::ADDR_W_DEF,
  parameter int unsigned COL_W  = pwe_pkg::COL_W_DEF,
  parameter int unsigned DATA_W = pwe_pkg::DATA_W_DEF,
  localparam int unsigned PAGE_W = ADDR_W - COL_W,
  localparam int unsigned NBYTES = 1 << COL_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [PAGE_W-1:0]             page_i,
  input  logic [NBYTES-1:0]             mask_i,
  input  logic [NBYTES-1:0][DATA_W-1:0] bytes_i,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [DATA_W-1:0]             rd_data_o
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DATA_W-1:0]            rd_q;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[w] <= '0;
      else if (we_i && page_i == WA[ADDR_W-1:COL_W] && mask_i[WA[COL_W-1:0]])
        mem_q[w] <= bytes_i[WA[COL_W-1:0]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;

  AST_ARRAY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q)) else $error("array changed without commit"); // R5
endmodule

// File: rtl/page_wr_engine.sv
module page_wr_engine #(
  parameter int unsigned ADDR_W    = pwe_pkg::ADDR_W_DEF,
  parameter int unsigned COL_W     = pwe_pkg::COL_W_DEF,
  parameter int unsigned DATA_W    = pwe_pkg::DATA_W_DEF,
  parameter int unsigned WR_CYCLES = 1250000,
  localparam int unsigned PAGE_W = ADDR_W - COL_W,
  localparam int unsigned NBYTES = 1 << COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_ack_o,
  output logic              busy_o
);
  import pwe_pkg::*;

  phase_e                        phase;
  logic                          busy, done;
  logic                          close, load, push, start, rd_go;
  logic                          open;
  logic [PAGE_W-1:0]             page;
  logic [NBYTES-1:0]             mask;
  logic [NBYTES-1:0][DATA_W-1:0] bytes;
  logic                          rd_ack_q;

  assign phase = busy ? PH_COMMIT : PH_OPEN;

  // stop > address load > data
  always_comb begin
    close = 1'b0;
    load  = 1'b0;
    push  = 1'b0;
    rd_go = 1'b0;
    if (phase == PH_OPEN) begin
      close = stop_i;
      load  = addr_load_i && !stop_i;
      push  = data_valid_i && !addr_load_i && !stop_i && open;
      rd_go = rd_en_i;
    end
  end

  assign start = close && open && (|mask);

  pwe_page_buf #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (addr_i),
    .push_i  (push),
    .data_i  (data_i),
    .close_i (close),
    .page_o  (page),
    .bytes_o (bytes),
    .mask_o  (mask),
    .open_o  (open)
  );

  pwe_wr_timer #(.CYC(WR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  pwe_array #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (done),
    .page_i    (page),
    .mask_i    (mask),
    .bytes_i   (bytes),
    .rd_en_i   (rd_go),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_ack_q <= 1'b0;
    else         rd_ack_q <= rd_go;
  end

  assign rd_ack_o = rd_ack_q;
  assign busy_o   = busy;

  AST_NO_RD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rd_ack_o) else $error("read served while busy"); // R8
  AST_NO_EMPTY_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !busy_o && mask == '0 |=> !busy_o) else $error("empty commit"); // R7
  AST_BUF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mask) && $stable(page)) else $error("buffer touched while busy"); // R8
endmodule

// File: tb/page_wr_engine_tb_top.sv
module page_wr_engine_tb_top;
  localparam int WRC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 1'b0, data_valid = 1'b0, stop = 1'b0, rd_en = 1'b0;
  logic [6:0] addr = '0, rd_addr = '0;
  logic [7:0] data = '0;
  logic [7:0] rd_data;
  logic       rd_ack, busy;

  int n_chk = 0, n_bad = 0;
  logic [7:0] model [128];

  always #2 clk = ~clk;

  page_wr_engine #(.WR_CYCLES(WRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_load_i(addr_load), .addr_i(addr),
    .data_valid_i(data_valid), .data_i(data), .stop_i(stop), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_ack_o(rd_ack), .busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [6:0] a);
    @(negedge clk); addr_load = 1'b1; addr = a;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); data_valid = 1'b1; data = d;
    @(negedge clk); data_valid = 1'b0;
  endtask

  // stop, then measure how long busy stays high
  task automatic do_stop(input string req, input int exp_len);
    int len = 0;
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    while (busy && len < 4 * WRC) begin
      len++;
      @(negedge clk);
    end
    chk(req, len, exp_len);
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [7:0] exp);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(req, rd_ack, 1);
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 ack", rd_ack, 0);
    chk("R1 data", rd_data, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 128; i += 9) rd_chk("R1 array", 7'(i), 8'h00);
    @(negedge clk);
    chk("R9 ack idle", rd_ack, 0);

    // R2 R3 R4 R5 R6 sweep: every page, every start column, 0..6 bytes
    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 4; c++) begin
        int nb;
        nb = (p + c) % 7;
        do_load(7'(p * 4 + c));
        for (int k = 0; k < nb; k++) begin
          logic [7:0] d;
          d = 8'((p * 37 + c * 11 + k * 5 + 1) & 8'hff);
          do_byte(d);
          model[p * 4 + ((c + k) % 4)] = d;
        end
        if (nb == 0) do_stop("R7 no data no busy", 0);
        else         do_stop("R6 busy length", WRC);
        for (int b = 0; b < 4; b++)
          rd_chk(nb > 4 ? "R4 wrap overwrite" : "R5 page contents", 7'(p * 4 + b), model[p * 4 + b]);
      end
    end

    // R5 other pages untouched by a final commit
    do_load(7'd10);
    do_byte(8'hA5);
    model[10] = 8'hA5;
    do_stop("R6 busy length", WRC);
    rd_chk("R5 target", 7'd10, 8'hA5);
    rd_chk("R5 neighbour", 7'd9, model[9]);
    rd_chk("R5 neighbour", 7'd11, model[11]);
    rd_chk("R5 other page", 7'd14, model[14]);

    // R8 strobes during busy ignored
    do_load(7'd20);
    do_byte(8'h3C);
    model[20] = 8'h3C;
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R6 busy rises", busy, 1);
    rd_en = 1'b1; rd_addr = 7'd20;
    @(negedge clk); rd_en = 1'b0;
    chk("R8 no read while busy", rd_ack, 0);
    addr_load = 1'b1; addr = 7'd40;
    @(negedge clk); addr_load = 1'b0; data_valid = 1'b1; data = 8'hEE;
    @(negedge clk); data_valid = 1'b0;
    while (busy) @(negedge clk);
    do_byte(8'h77);
    do_stop("R8 dropped strobes start nothing", 0);
    rd_chk("R8 addr 20", 7'd20, 8'h3C);
    rd_chk("R8 addr 40", 7'd40, model[40]);
    rd_chk("R8 addr 21", 7'd21, model[21]);

    // R7 data without address, stop without transfer
    do_byte(8'h55);
    do_stop("R7 no transfer", 0);
    rd_chk("R7 data dropped", 7'd21, model[21]);

    // R10 stop beats load and data
    do_load(7'd60);
    do_byte(8'h81);
    model[60] = 8'h81;
    @(negedge clk); stop = 1'b1; addr_load = 1'b1; addr = 7'd100; data_valid = 1'b1; data = 8'h99;
    @(negedge clk); stop = 1'b0; addr_load = 1'b0; data_valid = 1'b0;
    chk("R10 stop wins", busy, 1);
    while (busy) @(negedge clk);
    rd_chk("R10 committed", 7'd60, 8'h81);
    rd_chk("R10 load dropped", 7'd100, model[100]);
    do_stop("R10 no transfer open", 0);

    // R10 load beats data
    @(negedge clk); addr_load = 1'b1; addr = 7'd101; data_valid = 1'b1; data = 8'h42;
    @(negedge clk); addr_load = 1'b0; data_valid = 1'b0;
    do_stop("R10 data dropped", 0);
    rd_chk("R10 addr 101", 7'd101, model[101]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule